// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand reference of a 16-bit segmented machine into a byte address. From an addressing-mode code, a choice of base register, a choice of index register and a displacement taken from the instruction, it forms a 16-bit offset. It then picks the segment register that the mode implies and combines the two into a 20-bit physical address. Beside the data modes it also covers instruction fetch (code segment with the instruction pointer), stack access (stack segment with the stack pointer) and the destination side of string moves (extra segment with the destination index).

The register values arrive as inputs every cycle. A request is marked by `in_valid_i`, and the result appears on registered outputs in the next cycle together with `out_valid_o`. When no request is present the outputs keep their last result. A segment-override request can replace the implied segment for the data modes.

Top module: `segaddr_unit`

## Requirements
- R1: The physical address is the selected segment value shifted left by 4 plus the zero-extended 16-bit offset, taken modulo 2^20 (DS=038Eh with offset 0032h gives 03912h; segment FFFFh with offset 0010h gives 00000h).
- R2: Mode 0 (direct) uses the displacement alone as the offset. Without an override it selects segment id 3 (DS). The segment id encoding is ES=0, CS=1, SS=2, DS=3.
- R3: The offset is computed per mode, with the sum wrapping modulo 2^16: mode 1 is base plus displacement, mode 2 is base plus index, mode 3 is base plus index plus displacement, and mode 4 is index plus displacement. The base is BX when `base_sel_i`=0 and BP when it is 1. The index is SI when `idx_sel_i`=0 and DI when it is 1.
- R4: When `disp_short_i`=1, only bits 7:0 of the displacement are used, sign-extended to 16 bits. When it is 0, all 16 bits are used.
- R5: In modes 1 to 3 without an override, a BP base selects SS (id 2) and a BX base selects DS (id 3). Mode 4 selects DS.
- R6: Mode 5 (fetch) uses IP as the offset and CS (id 1). The override and the displacement are ignored (CS=39B4h with IP=0514h gives 3A054h).
- R7: Mode 6 (stack) uses SP as the offset and SS (id 2). The override and the displacement are ignored.
- R8: Mode 7 (string destination) uses DI as the offset and ES (id 0). The override and the displacement are ignored.
- R9: In modes 0 to 4, `ovr_en_i`=1 replaces the implied segment with `ovr_seg_i`, using the same id encoding.
- R10: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high, and low otherwise.
- R11: Reset clears every output to zero. While `in_valid_i` is low, the offset, physical address and segment id keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code 0..7 |
| base_sel_i | input | 1 | Base register: 0 BX, 1 BP |
| idx_sel_i | input | 1 | Index register: 0 SI, 1 DI |
| disp_i | input | 16 | Displacement from the instruction |
| disp_short_i | input | 1 | Use sign-extended low byte of displacement |
| ovr_en_i | input | 1 | Segment override request |
| ovr_seg_i | input | 2 | Override segment id |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| sp_i | input | 16 | SP value |
| ip_i | input | 16 | Instruction pointer value |
| cs_i | input | 16 | Code segment value |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| es_i | input | 16 | Extra segment value |
| out_valid_o | output | 1 | Result valid, one cycle after request |
| offset_o | output | 16 | Effective offset |
| phys_o | output | 20 | Physical byte address |
| seg_id_o | output | 2 | Chosen segment id |

## Verification
The bench aims at the wrap points. An offset sum that carries past 16 bits must fold back, and a design that let the carry reach the segment add would land 64 KiB too high. A segment near FFFFh must wrap the 20-bit sum to low memory instead of being truncated wrongly. A negative short displacement has to reduce the offset, so a design that zero-extended it would point 256 bytes too far. The bench also checks that fetch, stack and string-destination requests ignore an override and a displacement, that a BP base moves the default to the stack segment, and that an idle cycle leaves the results untouched. A design that got any of these wrong would report the wrong segment id or a wrong address.

// File: rtl/sea_pkg.sv
// Shared encodings for the segmented effective address generator.
// Assumes mode codes 0..7 and a two-bit segment id in the machine's order.
package sea_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT     = 3'd0,
        AM_BASE_DISP  = 3'd1,
        AM_BASE_IDX   = 3'd2,
        AM_BASE_IDX_D = 3'd3,
        AM_IDX_DISP   = 3'd4,
        AM_FETCH      = 3'd5,
        AM_STACK      = 3'd6,
        AM_STR_DST    = 3'd7
    } am_e;

    typedef enum logic [1:0] {
        SG_ES = 2'd0,
        SG_CS = 2'd1,
        SG_SS = 2'd2,
        SG_DS = 2'd3
    } sg_e;
endpackage

// File: rtl/sea_offset.sv
// Offset former: adds base, index and displacement terms as the mode asks,
// or passes IP, SP or DI for the implicit modes. The sum wraps at OFS_W bits.
// Assumes SHORT_W < OFS_W.
module sea_offset
    import sea_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic [2:0]       mode,
    input  logic             base_sel,
    input  logic             idx_sel,
    input  logic [OFS_W-1:0] disp,
    input  logic             disp_short,
    input  logic [OFS_W-1:0] bx,
    input  logic [OFS_W-1:0] bp,
    input  logic [OFS_W-1:0] si,
    input  logic [OFS_W-1:0] di,
    input  logic [OFS_W-1:0] sp,
    input  logic [OFS_W-1:0] ip,
    output logic [OFS_W-1:0] offset,
    output logic             uses_bp
);
    localparam int EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] base_v, idx_v, disp_v;
    logic [OFS_W-1:0] base_t, idx_t, disp_t;
    am_e              am;

    // Pick the register operands and widen the displacement.
    always_comb begin
        am     = am_e'(mode);
        base_v = base_sel ? bp : bx;
        idx_v  = idx_sel ? di : si;
        disp_v = disp_short ? {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]} : disp;
    end

    // Gate each term by mode and form the wrapped sum.
    always_comb begin
        base_t  = '0;
        idx_t   = '0;
        disp_t  = '0;
        uses_bp = 1'b0;
        unique case (am)
            AM_DIRECT:     disp_t = disp_v;
            AM_BASE_DISP:  begin base_t = base_v; disp_t = disp_v; uses_bp = base_sel; end
            AM_BASE_IDX:   begin base_t = base_v; idx_t = idx_v; uses_bp = base_sel; end
            AM_BASE_IDX_D: begin base_t = base_v; idx_t = idx_v; disp_t = disp_v; uses_bp = base_sel; end
            AM_IDX_DISP:   begin idx_t = idx_v; disp_t = disp_v; end
            AM_FETCH:      base_t = ip;
            AM_STACK:      base_t = sp;
            AM_STR_DST:    base_t = di;
            default:       base_t = '0;
        endcase
        offset = base_t + idx_t + disp_t;
    end
endmodule

// File: rtl/sea_segsel.sv
// Segment chooser: implicit modes fix the segment, data modes default to
// DS (SS with a BP base) unless an override is requested.
// Assumes four segment registers indexed by the package's id encoding.
module sea_segsel
    import sea_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic [2:0]       mode,
    input  logic             uses_bp,
    input  logic             ovr_en,
    input  logic [1:0]       ovr_seg,
    input  logic [SEG_W-1:0] cs,
    input  logic [SEG_W-1:0] ds,
    input  logic [SEG_W-1:0] ss,
    input  logic [SEG_W-1:0] es,
    output logic [1:0]       seg_id,
    output logic [SEG_W-1:0] seg_base
);
    localparam int N_SEG = 4;

    logic [SEG_W-1:0] seg_tbl [N_SEG];

    // Lay the segment values out by id.
    always_comb begin
        seg_tbl[SG_ES] = es;
        seg_tbl[SG_CS] = cs;
        seg_tbl[SG_SS] = ss;
        seg_tbl[SG_DS] = ds;
    end

    // Decide the segment id by mode, base and override.
    always_comb begin
        unique case (am_e'(mode))
            AM_FETCH:   seg_id = SG_CS;
            AM_STACK:   seg_id = SG_SS;
            AM_STR_DST: seg_id = SG_ES;
            default:    seg_id = ovr_en ? ovr_seg : (uses_bp ? SG_SS : SG_DS);
        endcase
        seg_base = seg_tbl[seg_id];
    end
endmodule

// File: rtl/sea_phys.sv
// Physical address adder: segment shifted by SHIFT plus zero-extended offset,
// wrapping at the physical width. Assumes OFS_W <= SEG_W + SHIFT.
module sea_phys #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg_base,
    input  logic [OFS_W-1:0]       offset,
    output logic [SEG_W+SHIFT-1:0] phys
);
    localparam int PA_W = SEG_W + SHIFT;

    // Shift-and-add; the carry out of PA_W is dropped.
    always_comb begin
        phys = {seg_base, {SHIFT{1'b0}}} + PA_W'(offset);
    end
endmodule

// File: rtl/segaddr_unit.sv
// Top of the effective address generator: forms the offset, chooses the
// segment, adds them, and registers the result one cycle after in_valid_i.
// Assumes register inputs are stable in the cycle in_valid_i is high.
module segaddr_unit
    import sea_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int SHORT_W   = 8,
    localparam int PA_W     = SEG_W + SEG_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [2:0]       mode_i,
    input  logic             base_sel_i,
    input  logic             idx_sel_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic             disp_short_i,
    input  logic             ovr_en_i,
    input  logic [1:0]       ovr_seg_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    input  logic [OFS_W-1:0] sp_i,
    input  logic [OFS_W-1:0] ip_i,
    input  logic [SEG_W-1:0] cs_i,
    input  logic [SEG_W-1:0] ds_i,
    input  logic [SEG_W-1:0] ss_i,
    input  logic [SEG_W-1:0] es_i,
    output logic             out_valid_o,
    output logic [OFS_W-1:0] offset_o,
    output logic [PA_W-1:0]  phys_o,
    output logic [1:0]       seg_id_o
);
    logic [OFS_W-1:0] ofs_c;
    logic             uses_bp_c;
    logic [1:0]       seg_id_c;
    logic [SEG_W-1:0] seg_base_c;
    logic [PA_W-1:0]  phys_c;

    sea_offset #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_ofs (
        .mode(mode_i), .base_sel(base_sel_i), .idx_sel(idx_sel_i),
        .disp(disp_i), .disp_short(disp_short_i),
        .bx(bx_i), .bp(bp_i), .si(si_i), .di(di_i), .sp(sp_i), .ip(ip_i),
        .offset(ofs_c), .uses_bp(uses_bp_c)
    );

    sea_segsel #(.SEG_W(SEG_W)) u_seg (
        .mode(mode_i), .uses_bp(uses_bp_c), .ovr_en(ovr_en_i), .ovr_seg(ovr_seg_i),
        .cs(cs_i), .ds(ds_i), .ss(ss_i), .es(es_i),
        .seg_id(seg_id_c), .seg_base(seg_base_c)
    );

    sea_phys #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SEG_SHIFT)) u_pa (
        .seg_base(seg_base_c), .offset(ofs_c), .phys(phys_c)
    );

    // Capture a result on a request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            offset_o    <= '0;
            phys_o      <= '0;
            seg_id_o    <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) begin
                offset_o <= ofs_c;
                phys_o   <= phys_c;
                seg_id_o <= seg_id_c;
            end
        end
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid_o == $past(in_valid_i))); // R10
    AST_DIRECT_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == AM_DIRECT && !disp_short_i) |=> (offset_o == $past(disp_i))); // R2
    AST_BP_DEFAULT_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !ovr_en_i && base_sel_i && mode_i >= AM_BASE_DISP && mode_i <= AM_BASE_IDX_D)
        |=> (seg_id_o == SG_SS)); // R5
    AST_FETCH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == AM_FETCH) |=> (seg_id_o == SG_CS && offset_o == $past(ip_i))); // R6
    AST_STACK_SS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == AM_STACK) |=> (seg_id_o == SG_SS && offset_o == $past(sp_i))); // R7
    AST_STRDST_ES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i == AM_STR_DST) |=> (seg_id_o == SG_ES && offset_o == $past(di_i))); // R8
    AST_OVERRIDE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && ovr_en_i && mode_i <= AM_IDX_DISP) |=> (seg_id_o == $past(ovr_seg_i))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> ($stable(offset_o) && $stable(phys_o) && $stable(seg_id_o))); // R11
endmodule

// File: tb/segaddr_unit_tb_top.sv
module segaddr_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic        base_sel = 1'b0, idx_sel = 1'b0, disp_short = 1'b0, ovr_en = 1'b0;
    logic [1:0]  ovr_seg = '0;
    logic [15:0] disp = '0, bx = '0, bp = '0, si = '0, di = '0, sp = '0, ip = '0;
    logic [15:0] cs = '0, ds = '0, ss = '0, es = '0;
    logic        out_valid;
    logic [15:0] offset;
    logic [19:0] phys;
    logic [1:0]  seg_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    segaddr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .mode_i(mode),
        .base_sel_i(base_sel), .idx_sel_i(idx_sel), .disp_i(disp),
        .disp_short_i(disp_short), .ovr_en_i(ovr_en), .ovr_seg_i(ovr_seg),
        .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di), .sp_i(sp), .ip_i(ip),
        .cs_i(cs), .ds_i(ds), .ss_i(ss), .es_i(es),
        .out_valid_o(out_valid), .offset_o(offset), .phys_o(phys), .seg_id_o(seg_id)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference of one request, from the current inputs.
    function automatic void ref_calc(output int o, output int s, output int p, output string tag);
        int b, x, d, sv;
        b = base_sel ? int'(bp) : int'(bx);
        x = idx_sel ? int'(di) : int'(si);
        d = disp_short ? ((int'(disp) & 255) - ((int'(disp) & 128) * 2)) : int'(disp);
        tag = "R3";
        case (mode)
            3'd0: begin o = d; tag = "R2"; end
            3'd1: o = b + d;
            3'd2: o = b + x;
            3'd3: o = b + x + d;
            3'd4: o = x + d;
            3'd5: begin o = int'(ip); tag = "R6"; end
            3'd6: begin o = int'(sp); tag = "R7"; end
            default: begin o = int'(di); tag = "R8"; end
        endcase
        o = o & 32'hFFFF;
        if (mode == 3'd5) s = 1;
        else if (mode == 3'd6) s = 2;
        else if (mode == 3'd7) s = 0;
        else if (ovr_en) begin s = int'(ovr_seg); tag = "R9"; end
        else if (base_sel && mode >= 3'd1 && mode <= 3'd3) begin s = 2; tag = "R5"; end
        else s = 3;
        if (disp_short && mode <= 3'd4 && mode != 3'd2) tag = "R4";
        case (s)
            0: sv = int'(es);
            1: sv = int'(cs);
            2: sv = int'(ss);
            default: sv = int'(ds);
        endcase
        p = (sv * 16 + o) & 32'hFFFFF;
    endfunction

    // Cycle model: expected outputs after each clock edge.
    int    e_v = 0, e_o = 0, e_s = 0, e_p = 0;
    string e_tag = "R11";
    always @(posedge clk) begin
        int o, s, p;
        string t;
        if (!rst_n) begin
            e_v <= 0; e_o <= 0; e_s <= 0; e_p <= 0; e_tag <= "R11";
        end else begin
            e_v <= int'(in_valid);
            if (in_valid) begin
                ref_calc(o, s, p, t);
                e_o <= o; e_s <= s; e_p <= p; e_tag <= t;
            end else e_tag <= "R11";
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10", "out_valid", int'(out_valid), e_v);
            chk(e_tag, "offset", int'(offset), e_o);
            chk(e_tag, "seg_id", int'(seg_id), e_s);
            chk("R1", "phys", int'(phys), e_p);
        end
    end

    task automatic req(input logic [2:0] m, input bit bs, input bit xs, input bit sh,
                       input bit oe, input logic [1:0] os, input logic [15:0] d);
        mode = m; base_sel = bs; idx_sel = xs; disp_short = sh;
        ovr_en = oe; ovr_seg = os; disp = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset valid", int'(out_valid), 0);
        chk("R11", "reset phys", int'(phys), 0);
        chk("R11", "reset offset", int'(offset), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Direct data reference with literal expectation.
        ds = 16'h038E;
        req(3'd0, 0, 0, 0, 0, 2'd0, 16'h0032);
        chk("R1", "direct phys literal", int'(phys), 32'h03912);
        chk("R2", "direct seg literal", int'(seg_id), 3);
        // Fetch with override and displacement present.
        cs = 16'h39B4; ip = 16'h0514;
        req(3'd5, 0, 0, 0, 1, 2'd0, 16'h1234);
        chk("R6", "fetch phys literal", int'(phys), 32'h3A054);
        // Segment wrap at the top of memory.
        ds = 16'hFFFF;
        req(3'd0, 0, 0, 0, 0, 2'd0, 16'h0010);
        chk("R1", "segment wrap literal", int'(phys), 0);
        // Offset wrap: BX + SI beyond 16 bits.
        bx = 16'hFFFF; si = 16'h0002; ds = 16'h1000;
        req(3'd2, 0, 0, 0, 0, 2'd0, 16'h0000);
        chk("R3", "offset wrap literal", int'(offset), 1);
        chk("R3", "offset wrap phys", int'(phys), 32'h10001);
        // Negative short displacement.
        bp = 16'h0100; ss = 16'h2000;
        req(3'd1, 1, 0, 1, 0, 2'd0, 16'h55FE);
        chk("R4", "short disp literal", int'(offset), 32'h00FE);
        chk("R5", "bp base seg", int'(seg_id), 2);
        // Stack and string destination ignore the override.
        sp = 16'hFFEE; di = 16'h0040; es = 16'h3000;
        req(3'd6, 0, 0, 0, 1, 2'd3, 16'h0777);
        chk("R7", "stack seg", int'(seg_id), 2);
        req(3'd7, 0, 1, 0, 1, 2'd1, 16'h0777);
        chk("R8", "strdst phys", int'(phys), 32'h30040);
        // Override in a data mode; idle hold afterwards.
        req(3'd3, 1, 1, 0, 1, 2'd0, 16'h0001);
        chk("R9", "override seg", int'(seg_id), 0);
        repeat (3) @(negedge clk);
        chk("R11", "hold seg", int'(seg_id), 0);

        // Mixed stimulus over all modes.
        for (int i = 0; i < 4000; i++) begin
            mode = 3'($urandom); base_sel = 1'($urandom); idx_sel = 1'($urandom);
            disp_short = 1'($urandom); ovr_en = 1'($urandom); ovr_seg = 2'($urandom);
            disp = 16'($urandom); bx = 16'($urandom); bp = 16'($urandom);
            si = 16'($urandom); di = 16'($urandom); sp = 16'($urandom); ip = 16'($urandom);
            cs = 16'($urandom); ds = 16'($urandom); ss = 16'($urandom); es = 16'($urandom);
            in_valid = ($urandom % 4) != 0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule